// File: doc/BRIEF.md
# Dual-Issue Pair Dependency Checker

This block sits between decode and issue in a two-wide in-order pipeline. It holds a window of two decoded instructions, an older one and a younger one in program order. Each cycle it decides whether the pair may leave together or whether only the older one may leave. The younger one is held back when it depends on the older one. The checks cover a read of the older one's result, a write to the same destination, and a clash on the single divider.

Incoming instructions fill free window slots in program order. A younger instruction that was held back moves into the older slot. The first new instruction then takes the younger slot in the same cycle. A downstream ready signal can stall issue. During a stall both slots keep their contents, and only empty slots may be filled.

Top module: `dip_pair_issue`

## Requirements
- R1: After reset both slots are empty, `out_vld` is 0, `iss_mask` is 2'b00 and `iss_cnt` is 0.
- R2: When both slots are valid, `ds_ready` is 1 and no hazard exists, `iss_mask` is 2'b11 (bit 0 = older slot, bit 1 = younger slot) and `iss_cnt` is 2.
- R3: When the older instruction writes a nonzero register that the younger reads as source 1 or source 2, only the older issues: `iss_mask` is 2'b01.
- R4: When both instructions write the same nonzero register, only the older issues.
- R5: When both instructions carry the divide class (class code 2; 0 = ALU, 1 = multiply, 3 = memory), only the older issues. Two divides never leave together.
- R6: Register 0 as the older destination, or an older instruction whose write flag is 0, creates no read or write hazard.
- R7: With `ds_ready` low, `iss_mask` is 2'b00 and every occupied slot keeps its contents.
- R8: After a single issue with a valid younger slot, the next cycle shows the former younger instruction in the older slot. In that same edge, the first offered new instruction goes into the younger slot.
- R9: `iss_mask` bit 1 is never set without bit 0, and `iss_cnt` equals the number of set mask bits.
- R10: `take_cnt` equals the smaller of the offered count (`in_vld` 2'b01 = one, 2'b11 = two) and the free slots left after issue. Offered lane 0 is placed ahead of lane 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 2 | Offered instructions, lane 0 older; 2'b10 not allowed |
| in_wr | input | 2 | Per-lane destination write flag |
| in_rd | input | 2*REG_W | Per-lane destination register |
| in_rs1 | input | 2*REG_W | Per-lane first source register |
| in_rs2 | input | 2*REG_W | Per-lane second source register |
| in_cls | input | 4 | Per-lane operation class, 2 bits each |
| take_cnt | output | 2 | Number of offered instructions accepted this cycle |
| ds_ready | input | 1 | Downstream can accept issued instructions |
| out_vld | output | 1 | Older slot holds an instruction |
| out_wr | output | 2 | Slot write flags, bit 0 older |
| out_rd | output | 2*REG_W | Slot destination registers |
| out_rs1 | output | 2*REG_W | Slot first sources |
| out_rs2 | output | 2*REG_W | Slot second sources |
| out_cls | output | 4 | Slot classes |
| iss_mask | output | 2 | Slots issuing this cycle |
| iss_cnt | output | 2 | Number of instructions issuing (0, 1, 2) |

## Verification
The bench sweeps every combination of older write flag, destination and class against the younger write flag, destination, both sources and class. It uses 2-bit register numbers. A checker that ignored source 2, treated register 0 as a real destination, or let two divides pair would issue 2'b11 where 2'b01 is due. After each split pair the bench checks that the younger instruction moved into the older slot. A slot queue that dropped it or reordered it would show the wrong destination there. Directed cases cover refill during a split, a one-lane offer, and offers made during a stall. In those cases a wrong `take_cnt` would lose instructions or accept them twice.

// File: rtl/dip_pkg.sv
package dip_pkg;
  typedef enum logic [1:0] {
    OPC_ALU = 2'd0,
    OPC_MUL = 2'd1,
    OPC_DIV = 2'd2,
    OPC_MEM = 2'd3
  } opc_e;
  localparam int OPC_W = 2;
endpackage

// File: rtl/dip_hazard.sv
module dip_hazard #(
  parameter int REG_W = 5
) (
  input  logic             o_wr,
  input  logic [REG_W-1:0] o_rd,
  input  logic [1:0]       o_cls,
  input  logic             y_wr,
  input  logic [REG_W-1:0] y_rd,
  input  logic [REG_W-1:0] y_rs1,
  input  logic [REG_W-1:0] y_rs2,
  input  logic [1:0]       y_cls,
  output logic             pair_ok
);
  import dip_pkg::*;

  logic o_dst_live;
  logic raw_hit;
  logic waw_hit;
  logic div_hit;

  always_comb begin
    o_dst_live = o_wr && (o_rd != '0);
    raw_hit    = o_dst_live && ((y_rs1 == o_rd) || (y_rs2 == o_rd));
    waw_hit    = o_dst_live && y_wr && (y_rd == o_rd);
    div_hit    = (opc_e'(o_cls) == OPC_DIV) && (opc_e'(y_cls) == OPC_DIV);
    pair_ok    = !(raw_hit || waw_hit || div_hit);
  end
endmodule

// File: rtl/dip_slots.sv
module dip_slots #(
  parameter int DW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         in_vld,
  input  logic [1:0][DW-1:0] in_dat,
  input  logic [1:0]         iss_mask,
  output logic [1:0]         s_vld,
  output logic [1:0][DW-1:0] s_dat,
  output logic [1:0]         take_cnt
);
  logic [1:0]         vld_q, vld_d;
  logic [1:0][DW-1:0] dat_q, dat_d;
  logic               keep0, keep1;
  logic [1:0]         rem_cnt, avail, free_cnt, take;
  logic               upd_en;

  always_comb begin
    keep0    = vld_q[0] && !iss_mask[0];
    keep1    = vld_q[1] && !iss_mask[1];
    rem_cnt  = {1'b0, keep0} + {1'b0, keep1};
    avail    = in_vld[0] ? (in_vld[1] ? 2'd2 : 2'd1) : 2'd0;
    free_cnt = 2'd2 - rem_cnt;
    take     = (avail < free_cnt) ? avail : free_cnt;
    upd_en   = (|iss_mask) || (take != 2'd0);

    vld_d = '0;
    dat_d = dat_q;
    if (rem_cnt == 2'd2) begin
      vld_d = 2'b11;
    end else if (rem_cnt == 2'd1) begin
      vld_d[0] = 1'b1;
      dat_d[0] = keep0 ? dat_q[0] : dat_q[1];
      if (take != 2'd0) begin
        vld_d[1] = 1'b1;
        dat_d[1] = in_dat[0];
      end
    end else begin
      if (take != 2'd0) begin
        vld_d[0] = 1'b1;
        dat_d[0] = in_dat[0];
      end
      if (take == 2'd2) begin
        vld_d[1] = 1'b1;
        dat_d[1] = in_dat[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
    end else if (upd_en) begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign s_vld    = vld_q;
  assign s_dat    = dat_q;
  assign take_cnt = take;

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q[1] |-> vld_q[0]); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[0] && !iss_mask[0]) |=> (vld_q[0] && (dat_q[0] == $past(dat_q[0])))); // R7
  AST_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_mask == 2'b01 && vld_q[1]) |=> (vld_q[0] && (dat_q[0] == $past(dat_q[1])))); // R8
endmodule

// File: rtl/dip_pair_issue.sv
module dip_pair_issue #(
  parameter int REG_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         in_vld,
  input  logic [1:0]         in_wr,
  input  logic [2*REG_W-1:0] in_rd,
  input  logic [2*REG_W-1:0] in_rs1,
  input  logic [2*REG_W-1:0] in_rs2,
  input  logic [3:0]         in_cls,
  output logic [1:0]         take_cnt,
  input  logic               ds_ready,
  output logic               out_vld,
  output logic [1:0]         out_wr,
  output logic [2*REG_W-1:0] out_rd,
  output logic [2*REG_W-1:0] out_rs1,
  output logic [2*REG_W-1:0] out_rs2,
  output logic [3:0]         out_cls,
  output logic [1:0]         iss_mask,
  output logic [1:0]         iss_cnt
);
  import dip_pkg::*;

  localparam int DW = 1 + 3*REG_W + OPC_W;

  logic               rst_meta, rst_sync;
  logic [1:0][DW-1:0] in_dat, s_dat;
  logic [1:0]         s_vld;
  logic               pair_ok;
  logic               fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_lane
    assign in_dat[k] = {in_wr[k], in_rd[k*REG_W +: REG_W], in_rs1[k*REG_W +: REG_W],
                        in_rs2[k*REG_W +: REG_W], in_cls[k*OPC_W +: OPC_W]};
    assign {out_wr[k], out_rd[k*REG_W +: REG_W], out_rs1[k*REG_W +: REG_W],
            out_rs2[k*REG_W +: REG_W], out_cls[k*OPC_W +: OPC_W]} = s_dat[k];
  end

  dip_hazard #(.REG_W(REG_W)) hz_i (
    .o_wr   (out_wr[0]),
    .o_rd   (out_rd[REG_W-1:0]),
    .o_cls  (out_cls[1:0]),
    .y_wr   (out_wr[1]),
    .y_rd   (out_rd[2*REG_W-1:REG_W]),
    .y_rs1  (out_rs1[2*REG_W-1:REG_W]),
    .y_rs2  (out_rs2[2*REG_W-1:REG_W]),
    .y_cls  (out_cls[3:2]),
    .pair_ok(pair_ok)
  );

  always_comb begin
    fire     = s_vld[0] && ds_ready;
    iss_mask = {fire && s_vld[1] && pair_ok, fire};
    iss_cnt  = iss_mask[1] ? 2'd2 : {1'b0, iss_mask[0]};
  end

  assign out_vld = s_vld[0];

  dip_slots #(.DW(DW)) slots_i (
    .clk     (clk),
    .rst_n   (rst_sync),
    .in_vld  (in_vld),
    .in_dat  (in_dat),
    .iss_mask(iss_mask),
    .s_vld   (s_vld),
    .s_dat   (s_dat),
    .take_cnt(take_cnt)
  );

  AST_MASK_ORDER: assert property (@(posedge clk) disable iff (!rst_sync)
    iss_mask[1] |-> iss_mask[0]); // R9
  AST_NO_DUAL_DIV: assert property (@(posedge clk) disable iff (!rst_sync)
    (iss_mask == 2'b11) |-> !((out_cls[1:0] == 2'd2) && (out_cls[3:2] == 2'd2))); // R5
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_sync)
    !ds_ready |-> (iss_mask == 2'b00)); // R7
  AST_NO_RAW_PAIR: assert property (@(posedge clk) disable iff (!rst_sync)
    (iss_mask == 2'b11 && out_wr[0] && out_rd[REG_W-1:0] != '0)
      |-> (out_rs1[2*REG_W-1:REG_W] != out_rd[REG_W-1:0]
           && out_rs2[2*REG_W-1:REG_W] != out_rd[REG_W-1:0])); // R3
endmodule

// File: tb/dip_pair_issue_tb.sv
module dip_pair_issue_tb_top;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    in_vld = '0;
  logic [1:0]    in_wr = '0;
  logic [2*RW-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [3:0]    in_cls = '0;
  logic [1:0]    take_cnt;
  logic          ds_ready = 1'b0;
  logic          out_vld;
  logic [1:0]    out_wr;
  logic [2*RW-1:0] out_rd, out_rs1, out_rs2;
  logic [3:0]    out_cls;
  logic [1:0]    iss_mask, iss_cnt;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dip_pair_issue #(.REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_wr(in_wr), .in_rd(in_rd),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_cls(in_cls), .take_cnt(take_cnt),
    .ds_ready(ds_ready), .out_vld(out_vld), .out_wr(out_wr), .out_rd(out_rd),
    .out_rs1(out_rs1), .out_rs2(out_rs2), .out_cls(out_cls),
    .iss_mask(iss_mask), .iss_cnt(iss_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_lane(input int k, input bit wr, input int rd, input int rs1,
                          input int rs2, input int cls);
    in_wr[k]            = wr;
    in_rd[k*RW +: RW]   = RW'(rd);
    in_rs1[k*RW +: RW]  = RW'(rs1);
    in_rs2[k*RW +: RW]  = RW'(rs2);
    in_cls[k*2 +: 2]    = 2'(cls);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
    chk(iss_mask == 2'b00, "R1 iss_mask", int'(iss_mask), 0);
    chk(iss_cnt == 2'd0, "R1 iss_cnt", int'(iss_cnt), 0);

    // exhaustive pair sweep
    for (int c = 0; c < 16384; c++) begin
      bit owr, ywr, raw, waw, dv, haz;
      int ord, ocls, yrd, yrs1, yrs2, ycls, expm;
      string tag;
      owr  = c[0];     ord  = (c >> 1) & 3;  ocls = (c >> 3) & 3;
      ywr  = c[5];     yrd  = (c >> 6) & 3;  yrs1 = (c >> 8) & 3;
      yrs2 = (c >> 10) & 3; ycls = (c >> 12) & 3;
      raw  = owr && ord != 0 && (yrs1 == ord || yrs2 == ord);
      waw  = owr && ywr && ord != 0 && yrd == ord;
      dv   = (ocls == 2) && (ycls == 2);
      haz  = raw || waw || dv;
      expm = haz ? 1 : 3;
      if (dv) tag = "R5";
      else if (raw) tag = "R3";
      else if (waw) tag = "R4";
      else if (!owr || ord == 0) tag = "R6";
      else tag = "R2";

      @(negedge clk);
      ds_ready = 1'b0;
      in_vld = 2'b11;
      set_lane(0, owr, ord, 0, 0, ocls);
      set_lane(1, ywr, yrd, yrs1, yrs2, ycls);
      #1;
      if (c < 64) chk(take_cnt == 2'd2, "R10 take two", int'(take_cnt), 2);
      @(negedge clk);
      in_vld = 2'b00;
      #1;
      if (c < 64) begin
        chk(iss_mask == 2'b00, "R7 stall mask", int'(iss_mask), 0);
        chk(out_rd == {RW'(yrd), RW'(ord)}, "R7 stall hold", int'(out_rd), (yrd << RW) | ord);
      end
      ds_ready = 1'b1;
      #1;
      chk(iss_mask == 2'(expm), tag, int'(iss_mask), expm);
      chk(iss_cnt == (haz ? 2'd1 : 2'd2), "R9 count", int'(iss_cnt), haz ? 1 : 2);
      if (haz) begin
        @(negedge clk);
        #1;
        chk(out_vld && out_rd[RW-1:0] == RW'(yrd) && out_cls[1:0] == 2'(ycls),
            "R8 promote", int'(out_rd[RW-1:0]), yrd);
        chk(iss_mask == 2'b01, "R8 single", int'(iss_mask), 1);
      end
      @(negedge clk);
      ds_ready = 1'b0;
      #1;
      if (c < 64) chk(out_vld == 1'b0, "R10 drained", int'(out_vld), 0);
    end

    // refill during a split issue
    @(negedge clk);
    in_vld = 2'b11;
    set_lane(0, 1, 1, 0, 0, 0);
    set_lane(1, 1, 2, 1, 0, 0);
    @(negedge clk);
    ds_ready = 1'b1;
    set_lane(0, 1, 3, 0, 0, 1);
    set_lane(1, 1, 1, 0, 0, 3);
    #1;
    chk(iss_mask == 2'b01, "R3 split", int'(iss_mask), 1);
    chk(take_cnt == 2'd1, "R10 take one on split", int'(take_cnt), 1);
    @(negedge clk);
    ds_ready = 1'b0;
    in_vld = 2'b11;
    #1;
    chk(out_rd[RW-1:0] == 2'd2, "R8 older from younger", int'(out_rd[RW-1:0]), 2);
    chk(out_rd[2*RW-1:RW] == 2'd3, "R8 younger from lane0", int'(out_rd[2*RW-1:RW]), 3);
    chk(take_cnt == 2'd0, "R10 full no take", int'(take_cnt), 0);
    ds_ready = 1'b1;
    in_vld = 2'b00;
    #1;
    chk(iss_mask == 2'b11, "R2 refilled pair", int'(iss_mask), 3);
    @(negedge clk);
    ds_ready = 1'b0;
    in_vld = 2'b01;
    set_lane(0, 0, 0, 0, 0, 2);
    #1;
    chk(take_cnt == 2'd1, "R10 one lane", int'(take_cnt), 1);
    @(negedge clk);
    in_vld = 2'b00;
    #1;
    chk(out_vld && iss_mask == 2'b00, "R7 single held", int'(out_vld), 1);
    ds_ready = 1'b1;
    #1;
    chk(iss_mask == 2'b01 && iss_cnt == 2'd1, "R9 lone older", int'(iss_mask), 1);
    @(negedge clk);
    ds_ready = 1'b0;
    #1;
    chk(out_vld == 1'b0, "R10 empty", int'(out_vld), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule